// File: doc/BRIEF.md
# First-Come-First-Served Offload Task Dispatcher

This block sits between a host driver's register writes and a pool of compute processing elements inside a storage controller. The driver writes a task descriptor in one cycle. A descriptor holds two source ranges, two destination ranges (each range is a 64-bit address and a 64-bit length), a 32-bit task code and a 32-bit parameter word. The descriptor enters an eight-entry queue and receives a sequence tag. The head of the queue is issued to a free element whose kind matches the task code. Issue follows arrival order strictly, and the block checks no dependencies between tasks. Several elements can work at the same time.

Each finished task produces a one-cycle completion pulse that carries its tag and a status code. A maintenance unit (garbage collection, wear levelling) raises a request. This halts all new dispatch. The grant comes back only after every task already issued has finished. The unit can also sample a busy flag.

Top module: `fcfs_task_dispatcher`

## Requirements
- R1: After reset, q_full, eng_busy, maint_grant, cpl_valid, pe_start and pe_ack are all low.
- R2: A write with wr_valid high is accepted when q_full is low. Accepted writes take tags 0,1,2,... in order, modulo 16. q_full rises once 8 descriptors are queued. A write made while q_full is high is dropped and consumes no tag.
- R3: Descriptors leave the queue strictly in arrival order. If the head has no free element of its kind, nothing behind it is issued.
- R4: Element i serves task code i mod KINDS (KINDS=2, four elements). A valid head goes to the lowest-numbered free element of its kind with a one-cycle pe_start pulse. During that pulse iss_tag, iss_code, iss_param and iss_desc are valid. iss_desc is {src0_addr, src0_len, src1_addr, src1_len, dst0_addr, dst0_len, dst1_addr, dst1_len}, with src0_addr in the top 64 bits.
- R5: Tasks on different elements run concurrently: a new task can be issued while earlier ones are still in flight.
- R6: An element holds pe_done high until pe_ack answers it. The cycle after the ack, cpl_valid pulses with that element's task tag and cpl_status 0. At most one completion is reported per cycle.
- R7: A head whose task code is KINDS or more completes with cpl_status 1 and is never issued. A head whose data type field task_param[1:0] is 3 completes with cpl_status 2 and is never issued. The values 0 (integer), 1 (single float) and 2 (double float) are issued normally.
- R8: While maint_req is high, no task is issued and no descriptor leaves the queue. maint_grant goes high the cycle after maint_req is seen with no element busy.
- R9: eng_busy is high exactly while at least one element holds an issued task that has not yet been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Descriptor write strobe |
| src0_addr | input | 64 | First source address |
| src0_len | input | 64 | First source length |
| src1_addr | input | 64 | Second source address |
| src1_len | input | 64 | Second source length |
| dst0_addr | input | 64 | First destination address |
| dst0_len | input | 64 | First destination length |
| dst1_addr | input | 64 | Second destination address |
| dst1_len | input | 64 | Second destination length |
| task_code | input | 32 | Task kind selector |
| task_param | input | 32 | Parameter word; bits 1:0 give the data type |
| q_full | output | 1 | Queue holds 8 descriptors |
| pe_start | output | 4 | One-hot issue pulse per element |
| iss_desc | output | 512 | Ranges of the issued task |
| iss_code | output | 32 | Task code of the issued task |
| iss_param | output | 32 | Parameter word of the issued task |
| iss_tag | output | 4 | Tag of the issued task |
| pe_done | input | 4 | Per-element completion request, held until acked |
| pe_ack | output | 4 | Per-element completion acknowledge |
| cpl_valid | output | 1 | Completion pulse |
| cpl_tag | output | 4 | Tag of the completed task |
| cpl_status | output | 2 | 0 ok, 1 unknown task code, 2 bad data type |
| maint_req | input | 1 | Maintenance request |
| maint_grant | output | 1 | Maintenance may proceed |
| eng_busy | output | 1 | Some element holds a task |

## Verification
The hardest case is a head task waiting for its kind while a younger task of another kind has a free element. Reaching it needs both elements of one kind kept busy by long latencies. The bench sets the model latencies per element so that a third same-kind task sits at the head, with an other-kind task queued behind it. The issue-order scoreboard then catches any bypass. The full-queue case uses maintenance to freeze dispatch while eight descriptors and a ninth rejected one are written.

// File: rtl/fcfs_task_dispatcher.sv
module fcfs_task_dispatcher #(
  parameter int PE_COUNT = 4,
  parameter int KINDS    = 2,
  parameter int DEPTH    = 8,
  parameter int TAG_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_valid,
  input  logic [63:0]           src0_addr,
  input  logic [63:0]           src0_len,
  input  logic [63:0]           src1_addr,
  input  logic [63:0]           src1_len,
  input  logic [63:0]           dst0_addr,
  input  logic [63:0]           dst0_len,
  input  logic [63:0]           dst1_addr,
  input  logic [63:0]           dst1_len,
  input  logic [31:0]           task_code,
  input  logic [31:0]           task_param,
  output logic                  q_full,
  output logic [PE_COUNT-1:0]   pe_start,
  output logic [511:0]          iss_desc,
  output logic [31:0]           iss_code,
  output logic [31:0]           iss_param,
  output logic [TAG_W-1:0]      iss_tag,
  input  logic [PE_COUNT-1:0]   pe_done,
  output logic [PE_COUNT-1:0]   pe_ack,
  output logic                  cpl_valid,
  output logic [TAG_W-1:0]      cpl_tag,
  output logic [1:0]            cpl_status,
  input  logic                  maint_req,
  output logic                  maint_grant,
  output logic                  eng_busy
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = (PE_COUNT > 1) ? $clog2(PE_COUNT) : 1;

  logic [511:0]      q_desc  [DEPTH];
  logic [31:0]       q_code  [DEPTH];
  logic [31:0]       q_param [DEPTH];
  logic [TAG_W-1:0]  q_tag   [DEPTH];
  logic [TAG_W-1:0]  pe_tag  [PE_COUNT];
  logic [AW-1:0]     rd_ptr, wr_ptr;
  logic [AW:0]       cnt;
  logic [TAG_W-1:0]  next_tag;
  logic [PE_COUNT-1:0] pe_busy;

  logic accept, head_ok, bad_code, bad_type, found, any_done, issue, err_pop, pop;
  logic [PW-1:0] sel, dsel;

  assign q_full   = (cnt == (AW+1)'(DEPTH));
  assign accept   = wr_valid && !q_full;
  assign head_ok  = (cnt != '0);
  assign bad_code = q_code[rd_ptr] >= 32'(KINDS);
  assign bad_type = q_param[rd_ptr][1:0] == 2'd3;
  assign eng_busy = |pe_busy;

  always_comb begin
    found = 1'b0; sel = '0; any_done = 1'b0; dsel = '0;
    for (int i = PE_COUNT-1; i >= 0; i--) begin
      if (!pe_busy[i] && 32'(i % KINDS) == q_code[rd_ptr]) begin
        found = 1'b1; sel = PW'(i);
      end
      if (pe_done[i] && pe_busy[i]) begin
        any_done = 1'b1; dsel = PW'(i);
      end
    end
  end

  assign issue   = head_ok && !maint_req && !bad_code && !bad_type && found;
  assign err_pop = head_ok && !maint_req && (bad_code || bad_type) && !any_done;
  assign pop     = issue || err_pop;
  assign pe_ack  = any_done ? (PE_COUNT'(1) << dsel) : '0;

  always_ff @(posedge clk) begin
    if (accept) begin
      q_desc[wr_ptr]  <= {src0_addr, src0_len, src1_addr, src1_len,
                          dst0_addr, dst0_len, dst1_addr, dst1_len};
      q_code[wr_ptr]  <= task_code;
      q_param[wr_ptr] <= task_param;
      q_tag[wr_ptr]   <= next_tag;
    end
    if (issue) begin
      iss_desc       <= q_desc[rd_ptr];
      iss_code       <= q_code[rd_ptr];
      iss_param      <= q_param[rd_ptr];
      iss_tag        <= q_tag[rd_ptr];
      pe_tag[sel]    <= q_tag[rd_ptr];
    end
    if (rst) begin
      rd_ptr <= '0; wr_ptr <= '0; cnt <= '0; next_tag <= '0;
      pe_busy <= '0; pe_start <= '0;
      cpl_valid <= 1'b0; cpl_tag <= '0; cpl_status <= '0;
      maint_grant <= 1'b0;
    end else begin
      if (accept) begin
        wr_ptr   <= wr_ptr + 1'b1;
        next_tag <= next_tag + 1'b1;
      end
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + (AW+1)'(accept) - (AW+1)'(pop);
      pe_start <= issue ? (PE_COUNT'(1) << sel) : '0;
      pe_busy  <= (pe_busy & ~pe_ack) | (issue ? (PE_COUNT'(1) << sel) : '0);
      cpl_valid <= any_done || err_pop;
      if (any_done) begin
        cpl_tag <= pe_tag[dsel]; cpl_status <= 2'd0;
      end else if (err_pop) begin
        cpl_tag <= q_tag[rd_ptr]; cpl_status <= bad_code ? 2'd1 : 2'd2;
      end
      maint_grant <= maint_req && (pe_busy == '0);
    end
  end

  p_maint_blocks_issue_r8: assert property (@(posedge clk) disable iff (rst)
    maint_req |=> (pe_start == '0));
  p_grant_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    maint_grant |-> !eng_busy);
  p_start_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pe_start));
  p_start_to_free_pe_r4: assert property (@(posedge clk) disable iff (rst)
    ((pe_start & $past(pe_busy)) == '0));
  p_full_drops_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && q_full) |=> $stable(next_tag));
  p_ack_gives_cpl_r6: assert property (@(posedge clk) disable iff (rst)
    (pe_ack != '0) |=> (cpl_valid && cpl_status == 2'd0));
  p_ack_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pe_ack));
endmodule

// File: tb/sim_fcfs_task_dispatcher.sv
module sim_fcfs_task_dispatcher;
  logic clk = 0, rst = 1;
  always #4 clk = ~clk;

  logic wr_valid = 0;
  logic [63:0] f [8];
  logic [31:0] task_code = 0, task_param = 0;
  logic q_full, cpl_valid, maint_req = 0, maint_grant, eng_busy;
  logic [3:0] pe_start, pe_ack, pe_done, iss_tag, cpl_tag;
  logic [511:0] iss_desc;
  logic [31:0] iss_code, iss_param;
  logic [1:0] cpl_status;

  fcfs_task_dispatcher u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid),
    .src0_addr(f[0]), .src0_len(f[1]), .src1_addr(f[2]), .src1_len(f[3]),
    .dst0_addr(f[4]), .dst0_len(f[5]), .dst1_addr(f[6]), .dst1_len(f[7]),
    .task_code(task_code), .task_param(task_param), .q_full(q_full),
    .pe_start(pe_start), .iss_desc(iss_desc), .iss_code(iss_code),
    .iss_param(iss_param), .iss_tag(iss_tag), .pe_done(pe_done),
    .pe_ack(pe_ack), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .cpl_status(cpl_status), .maint_req(maint_req),
    .maint_grant(maint_grant), .eng_busy(eng_busy));

  int checks = 0, fails = 0;
  int next_tag = 0;
  int exp_status [int];
  int exp_code [int];
  int issue_q [$];
  int inflight = 0, max_inflight = 0;
  int lat [4] = '{1, 1, 1, 1};
  int pcnt [4] = '{0, 0, 0, 0};
  logic [3:0] ack_seen;
  logic maint_d = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] word(input int tag, input int k);
    return {32'hC0DE0000 | 32'(k), 28'h0, 4'(tag)};
  endfunction

  task automatic put(input int code, input int dtype, output bit acc);
    @(negedge clk);
    acc = !q_full;
    for (int k = 0; k < 8; k++) f[k] = word(next_tag % 16, k);
    task_code = 32'(code);
    task_param = {24'h5A0000 >> 16, 6'h0, 2'(dtype)};
    wr_valid = 1;
    if (acc) begin
      exp_code[next_tag % 16] = code;
      if (code >= 2) exp_status[next_tag % 16] = 1;
      else if (dtype == 3) exp_status[next_tag % 16] = 2;
      else begin
        exp_status[next_tag % 16] = 0;
        issue_q.push_back(next_tag % 16);
      end
      next_tag++;
    end
    @(posedge clk); #1 wr_valid = 0;
  endtask

  task automatic drain();
    for (int n = 0; n < 2000 && exp_status.num() != 0; n++) @(negedge clk);
    chk(exp_status.num() == 0, "R6", "all completions returned", exp_status.num(), 0);
  endtask

  always @(posedge clk) ack_seen <= pe_ack;

  always @(negedge clk) begin
    if (rst) pe_done = 0;
    else for (int i = 0; i < 4; i++) begin
      if (pe_done[i] && ack_seen[i]) pe_done[i] = 0;
      if (pe_start[i]) pcnt[i] = lat[i];
      else if (pcnt[i] > 0) begin
        pcnt[i]--;
        if (pcnt[i] == 0) pe_done[i] = 1;
      end
    end
  end

  always @(negedge clk) if (!rst) begin
    if (pe_start != 0) begin
      int t, pe;
      t = issue_q.size() ? issue_q.pop_front() : -1;
      pe = $clog2(pe_start);
      chk(maint_d == 0, "R8", "issue during maintenance", pe_start, 0);
      chk(int'(iss_tag) == t, "R3", "issue order tag", iss_tag, t);
      chk(exp_code.exists(int'(iss_tag)) && pe % 2 == exp_code[int'(iss_tag)],
          "R4", "element kind", pe, iss_code);
      chk(iss_desc[511:448] == word(int'(iss_tag), 0) && iss_desc[63:0] == word(int'(iss_tag), 7),
          "R4", "descriptor fields", iss_desc[511:448], word(int'(iss_tag), 0));
      inflight++;
      if (inflight > max_inflight) max_inflight = inflight;
    end
    if (cpl_valid) begin
      int t;
      t = int'(cpl_tag);
      if (exp_status.exists(t)) begin
        chk(int'(cpl_status) == exp_status[t], exp_status[t] == 0 ? "R6" : "R7",
            "completion status", cpl_status, exp_status[t]);
        if (exp_status[t] == 0) inflight--;
        exp_status.delete(t);
      end else chk(0, "R6", "unexpected completion tag", t, -1);
    end
    chk(eng_busy == (inflight > 0), "R9", "busy flag", eng_busy, inflight > 0);
    maint_d = maint_req;
  end

  initial begin
    bit a;
    for (int k = 0; k < 8; k++) f[k] = 0;
    repeat (3) @(negedge clk);
    chk(!q_full && !eng_busy && !maint_grant && !cpl_valid && pe_start == 0 && pe_ack == 0,
        "R1", "reset outputs", {q_full, eng_busy, maint_grant, cpl_valid}, 0);
    rst = 0;
    // mixed kinds, out-of-order completion, all data types
    lat = '{6, 2, 9, 3};
    for (int j = 0; j < 6; j++) put(j % 2, j % 3, a);
    drain();
    chk(max_inflight >= 2, "R5", "parallel tasks in flight", max_inflight, 2);
    // error codes
    put(7, 0, a); put(0, 3, a); put(1, 1, a); put(2, 2, a);
    drain();
    // full queue with dispatch frozen
    @(negedge clk) maint_req = 1;
    for (int j = 0; j < 8; j++) put(j % 2, 0, a);
    @(negedge clk);
    chk(q_full == 1, "R2", "full after eight", q_full, 1);
    put(0, 0, a);
    chk(a == 0, "R2", "ninth write rejected", a, 0);
    @(negedge clk);
    chk(q_full == 1 && pe_start == 0, "R8", "queue frozen", q_full, 1);
    chk(maint_grant == 1, "R8", "grant while idle", maint_grant, 1);
    maint_req = 0;
    drain();
    // head stall: kind-0 elements busy, kind-1 task waits behind
    lat = '{40, 2, 40, 2};
    put(0, 0, a); put(0, 0, a); put(0, 0, a); put(1, 0, a);
    repeat (10) @(negedge clk);
    chk(issue_q.size() == 2, "R3", "no bypass of stalled head", issue_q.size(), 2);
    drain();
    // maintenance waits for running tasks
    lat = '{30, 30, 30, 30};
    put(0, 0, a); put(1, 1, a);
    repeat (4) @(negedge clk);
    maint_req = 1;
    put(0, 0, a);
    repeat (3) @(negedge clk);
    chk(maint_grant == 0 && eng_busy == 1, "R8", "no grant while busy", maint_grant, 0);
    for (int n = 0; n < 200 && !maint_grant; n++) @(negedge clk);
    chk(maint_grant == 1 && !eng_busy && inflight == 0, "R8", "grant after drain",
        maint_grant, 1);
    chk(issue_q.size() == 1, "R8", "queued task held", issue_q.size(), 1);
    maint_req = 0;
    drain();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule